// File: doc/BRIEF.md
# Shared-Table Branch Direction and Target Predictor

This block predicts conditional branches for an in-order core that runs two hardware threads. Each thread owns a global outcome history. One table of two-bit saturating counters serves both threads; the thread ID picks which half of it a lookup uses. Beside the table sits a set-associative target buffer that holds the taken targets of conditional branches.

A fetch lookup presents a PC, a thread ID and a hint that says whether the instruction is a conditional branch or an unconditional jump. The lookup returns a direction prediction, a target-valid flag, the predicted target and a taken-fetch decision, all within the same cycle. When a branch resolves, the update port carries its PC, thread, kind, outcome and target. The block then trains the table, the history and the target buffer. One cycle later it reports the class of penalty that the branch earned.

A table entry can also carry a sticky mark. The mark records that an entry has so far gone only one way, and while it is set the stored counter is neither consulted nor trained. Unconditional jumps are left out of all learning.

Top module: `bp_predictor`

## Requirements
- R1: After reset, a lookup returns lkDir=0, tgtValid=0 and predTaken=0 for every PC and thread, and penCycles reads 0.
- R2: The table index is the thread ID in the top bit, followed by that thread's 12-bit history XORed with PC[13:2]. The two threads never share an index.
- R3: Each entry holds a 2-bit counter that starts at 1. It counts up on taken and down on not-taken, and it saturates at 0 and 3. When the entry is unmarked, the predicted direction is counter bit 1.
- R4: The first conditional update of an entry marks it with its outcome and leaves the counter at 1. A marked entry predicts the marked direction. Further updates with that outcome leave the entry unchanged. The first opposite outcome clears the mark and trains the counter one step.
- R5: Each conditional update shifts its outcome into the least significant bit of the updating thread's history only. Lookups never change any history.
- R6: Unconditional updates (kind=1) change no history, no table entry and no target entry, and they give penCycles=0. A lookup with kind=1 returns tgtValid=0 and predTaken=0.
- R7: The target buffer has 32 sets of 4 ways. The set is PC[6:2] and the tag is PC[31:7]. A taken conditional update writes its target: into the matching way on a hit, and into a new way on a miss. A later conditional lookup of that PC returns tgtValid=1 and that target.
- R8: Replacement within a set takes the lowest-numbered invalid way first. When no way is invalid, it takes the way least recently written.
- R9: predTaken is 1 only when tgtValid=1 and lkDir=1. A target miss forces predTaken=0, while lkDir still shows the direction prediction.
- R10: On the cycle after a conditional update, penCycles shows the penalty. It is 13 when the direction predicted before the update differs from the outcome. It is 7 when a taken branch was predicted taken but missed in the target buffer. It is 0 in every other case, including cycles with no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkPc | input | 32 | Fetch PC to predict |
| lkTid | input | 1 | Thread of the fetch |
| lkKind | input | 1 | Fetch hint: 0 conditional, 1 unconditional |
| predTaken | output | 1 | Fetch should redirect to predTarget |
| lkDir | output | 1 | Direction prediction from the table |
| tgtValid | output | 1 | Target buffer hit |
| predTarget | output | 32 | Predicted target (valid with tgtValid) |
| upValid | input | 1 | A resolved branch is presented |
| upPc | input | 32 | PC of the resolved branch |
| upTid | input | 1 | Thread of the resolved branch |
| upKind | input | 1 | 0 conditional, 1 unconditional |
| upTaken | input | 1 | Resolved outcome |
| upTarget | input | 32 | Resolved target |
| penCycles | output | 4 | Penalty class of the previous update: 0, 7 or 13 |

## Verification
The bench builds the block with its default parameters: a 12-bit history, 8192 table entries and a 32-set, 4-way buffer. The random phase draws its PCs from six tags in two sets, which forces evictions and repeated refreshes in the buffer. A directed walk chooses the PC bits so that they cancel the moving history. Every update then lands on one table entry, and the saturation ends and the mark-clearing step can be seen at lkDir.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    MARK_NONE     = 2'd0,
    MARK_TAKEN    = 2'd1,
    MARK_NOTTAKEN = 2'd2
  } mark_e;

  typedef struct packed {
    mark_e      mark;
    logic [1:0] ctr;
  } phtEntry_t;

  localparam phtEntry_t FRESH_ENTRY = '{mark: MARK_NONE, ctr: 2'b01};

  localparam logic [3:0] PEN_NONE = 4'd0;
  localparam logic [3:0] PEN_TGT  = 4'd7;
  localparam logic [3:0] PEN_DIR  = 4'd13;

  // strobes from control to datapath
  typedef struct packed {
    logic      histShift;
    logic      histBit;
    logic      phtWr;
    phtEntry_t phtNew;
    logic      btbWr;
  } strobe_t;

  function automatic logic entryDir(phtEntry_t e);
    case (e.mark)
      MARK_TAKEN:    return 1'b1;
      MARK_NOTTAKEN: return 1'b0;
      default:       return e.ctr[1];
    endcase
  endfunction
endpackage

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 12,
  parameter int TID_W  = 1,
  parameter int SET_W  = 5,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   lkPc,
  input  logic [TID_W-1:0]  lkTid,
  input  logic [PC_W-1:0]   upPc,
  input  logic [TID_W-1:0]  upTid,
  input  logic [PC_W-1:0]   upTarget,
  input  strobe_t           strb,
  output phtEntry_t         lkEntry,
  output logic              lkHit,
  output logic [PC_W-1:0]   lkTarget,
  output phtEntry_t         upEntry,
  output logic              upFresh,
  output logic              upHit
);
  localparam int PHT_W   = TID_W + HIST_W;
  localparam int PHT_N   = 1 << PHT_W;
  localparam int THREADS = 1 << TID_W;
  localparam int SETS    = 1 << SET_W;
  localparam int TAG_W   = PC_W - SET_W - 2;
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;

  // per-thread history
  logic [HIST_W-1:0] hist [THREADS];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < THREADS; t++) hist[t] <= '0;
    end else if (strb.histShift) begin
      hist[upTid] <= {hist[upTid][HIST_W-2:0], strb.histBit};
    end
  end

  // shared pattern table
  logic [PHT_W-1:0] lkIdx, upIdx;
  assign lkIdx = {lkTid, hist[lkTid] ^ lkPc[HIST_W+1:2]};
  assign upIdx = {upTid, hist[upTid] ^ upPc[HIST_W+1:2]};

  phtEntry_t        phtMem [PHT_N];
  logic [PHT_N-1:0] phtSeen;

  always_ff @(posedge clk) begin
    if (rst) phtSeen <= '0;
    else if (strb.phtWr) phtSeen[upIdx] <= 1'b1;
  end
  always_ff @(posedge clk) begin
    if (strb.phtWr) phtMem[upIdx] <= strb.phtNew;
  end

  assign lkEntry = phtSeen[lkIdx] ? phtMem[lkIdx] : FRESH_ENTRY;
  assign upFresh = !phtSeen[upIdx];
  assign upEntry = upFresh ? FRESH_ENTRY : phtMem[upIdx];

  // target buffer
  logic             btbVld [SETS][WAYS];
  logic [TAG_W-1:0] btbTag [SETS][WAYS];
  logic [PC_W-1:0]  btbTgt [SETS][WAYS];
  logic [WAY_W-1:0] btbAge [SETS][WAYS];

  logic [SET_W-1:0] lkSet, upSet;
  logic [TAG_W-1:0] lkTag, upTag;
  assign lkSet = lkPc[SET_W+1:2];
  assign lkTag = lkPc[PC_W-1:SET_W+2];
  assign upSet = upPc[SET_W+1:2];
  assign upTag = upPc[PC_W-1:SET_W+2];

  logic unusedPcLow;
  assign unusedPcLow = ^{lkPc[1:0], upPc[1:0]};

  logic [WAY_W-1:0] hitWay, vicWay, oldWay, wrWay;
  logic             haveInv;

  always_comb begin
    lkHit    = 1'b0;
    lkTarget = '0;
    upHit    = 1'b0;
    hitWay   = '0;
    oldWay   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (btbVld[lkSet][w] && btbTag[lkSet][w] == lkTag) begin
        lkHit    = 1'b1;
        lkTarget = btbTgt[lkSet][w];
      end
      if (btbVld[upSet][w] && btbTag[upSet][w] == upTag) begin
        upHit  = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (btbAge[upSet][w] == WAY_W'(WAYS - 1)) oldWay = WAY_W'(w);
    end
    haveInv = 1'b0;
    vicWay  = oldWay;
    for (int w = 0; w < WAYS; w++) begin
      if (!haveInv && !btbVld[upSet][w]) begin
        haveInv = 1'b1;
        vicWay  = WAY_W'(w);
      end
    end
    wrWay = upHit ? hitWay : vicWay;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          btbVld[s][w] <= 1'b0;
          btbAge[s][w] <= WAY_W'(w);
        end
      end
    end else if (strb.btbWr) begin
      btbVld[upSet][wrWay] <= 1'b1;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == wrWay)
          btbAge[upSet][w] <= '0;
        else if (btbAge[upSet][w] < btbAge[upSet][wrWay])
          btbAge[upSet][w] <= btbAge[upSet][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.btbWr) begin
      btbTag[upSet][wrWay] <= upTag;
      btbTgt[upSet][wrWay] <= upTarget;
    end
  end
endmodule

// File: rtl/bp_control.sv
module bp_control
  import bp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upValid,
  input  logic       upKind,
  input  logic       upTaken,
  input  phtEntry_t  upEntry,
  input  logic       upFresh,
  input  logic       upHit,
  output strobe_t    strb,
  output logic [3:0] penCycles
);
  logic       condUp, predDir;
  logic [1:0] ctrNext;
  phtEntry_t  newEntry;
  logic [3:0] penNext;

  assign condUp  = upValid && !upKind;
  assign predDir = entryDir(upEntry);

  always_comb begin
    if (upTaken) ctrNext = (upEntry.ctr == 2'd3) ? 2'd3 : upEntry.ctr + 2'd1;
    else         ctrNext = (upEntry.ctr == 2'd0) ? 2'd0 : upEntry.ctr - 2'd1;

    if (upFresh) begin
      newEntry = '{mark: (upTaken ? MARK_TAKEN : MARK_NOTTAKEN), ctr: 2'b01};
    end else begin
      case (upEntry.mark)
        MARK_TAKEN:    newEntry = upTaken  ? upEntry : '{mark: MARK_NONE, ctr: ctrNext};
        MARK_NOTTAKEN: newEntry = !upTaken ? upEntry : '{mark: MARK_NONE, ctr: ctrNext};
        default:       newEntry = '{mark: MARK_NONE, ctr: ctrNext};
      endcase
    end

    strb.histShift = condUp;
    strb.histBit   = upTaken;
    strb.phtWr     = condUp;
    strb.phtNew    = newEntry;
    strb.btbWr     = condUp && upTaken;

    if (!condUp)                 penNext = PEN_NONE;
    else if (predDir != upTaken) penNext = PEN_DIR;
    else if (upTaken && !upHit)  penNext = PEN_TGT;
    else                         penNext = PEN_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) penCycles <= PEN_NONE;
    else     penCycles <= penNext;
  end
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 12,
  parameter int TID_W  = 1,
  parameter int SET_W  = 5,
  parameter int WAYS   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  lkPc,
  input  logic [TID_W-1:0] lkTid,
  input  logic             lkKind,
  output logic             predTaken,
  output logic             lkDir,
  output logic             tgtValid,
  output logic [PC_W-1:0]  predTarget,
  input  logic             upValid,
  input  logic [PC_W-1:0]  upPc,
  input  logic [TID_W-1:0] upTid,
  input  logic             upKind,
  input  logic             upTaken,
  input  logic [PC_W-1:0]  upTarget,
  output logic [3:0]       penCycles
);
  strobe_t   strb;
  phtEntry_t lkEntry, upEntry;
  logic      lkHit, upFresh, upHit;

  bp_datapath #(
    .PC_W(PC_W), .HIST_W(HIST_W), .TID_W(TID_W), .SET_W(SET_W), .WAYS(WAYS)
  ) u_dp (
    .clk(clk), .rst(rst), .lkPc(lkPc), .lkTid(lkTid), .upPc(upPc), .upTid(upTid),
    .upTarget(upTarget), .strb(strb), .lkEntry(lkEntry), .lkHit(lkHit),
    .lkTarget(predTarget), .upEntry(upEntry), .upFresh(upFresh), .upHit(upHit)
  );

  bp_control u_ctl (
    .clk(clk), .rst(rst), .upValid(upValid), .upKind(upKind), .upTaken(upTaken),
    .upEntry(upEntry), .upFresh(upFresh), .upHit(upHit), .strb(strb),
    .penCycles(penCycles)
  );

  assign lkDir     = entryDir(lkEntry);
  assign tgtValid  = lkHit && !lkKind;
  assign predTaken = tgtValid && lkDir;
endmodule

// File: rtl/bp_checker.sv
module bp_checker (
  input logic       clk,
  input logic       rst,
  input logic       lkKind,
  input logic       lkDir,
  input logic       tgtValid,
  input logic       predTaken,
  input logic       upValid,
  input logic       upKind,
  input logic       upTaken,
  input logic [3:0] penCycles
);
  p_miss_not_taken_r9: assert property (@(posedge clk) disable iff (rst)
    !tgtValid |-> !predTaken);
  p_hit_follows_dir_r9: assert property (@(posedge clk) disable iff (rst)
    tgtValid |-> (predTaken == lkDir));
  p_uncond_lookup_r6: assert property (@(posedge clk) disable iff (rst)
    lkKind |-> (!tgtValid && !predTaken));
  p_uncond_update_r6: assert property (@(posedge clk) disable iff (rst)
    (upValid && upKind) |=> (penCycles == 4'd0));
  p_idle_pen_r10: assert property (@(posedge clk) disable iff (rst)
    !upValid |=> (penCycles == 4'd0));
  p_pen_legal_r10: assert property (@(posedge clk) disable iff (rst)
    (penCycles == 4'd0) || (penCycles == 4'd7) || (penCycles == 4'd13));
  p_nt_no_tgt_pen_r10: assert property (@(posedge clk) disable iff (rst)
    (upValid && !upKind && !upTaken) |=> (penCycles != 4'd7));
  p_reset_pen_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (penCycles == 4'd0));
endmodule

bind bp_predictor bp_checker i_chk (
  .clk(clk), .rst(rst), .lkKind(lkKind), .lkDir(lkDir), .tgtValid(tgtValid),
  .predTaken(predTaken), .upValid(upValid), .upKind(upKind), .upTaken(upTaken),
  .penCycles(penCycles)
);

// File: tb/test_bp_predictor.sv
module test_bp_predictor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lkPc = '0;
  logic        lkTid = 1'b0, lkKind = 1'b0;
  logic        predTaken, lkDir, tgtValid;
  logic [31:0] predTarget;
  logic        upValid = 1'b0;
  logic [31:0] upPc = '0;
  logic        upTid = 1'b0, upKind = 1'b0, upTaken = 1'b0;
  logic [31:0] upTarget = '0;
  logic [3:0]  penCycles;

  int checks = 0;
  int failures = 0;

  bp_predictor i_bp_predictor (
    .clk(clk), .rst(rst), .lkPc(lkPc), .lkTid(lkTid), .lkKind(lkKind),
    .predTaken(predTaken), .lkDir(lkDir), .tgtValid(tgtValid), .predTarget(predTarget),
    .upValid(upValid), .upPc(upPc), .upTid(upTid), .upKind(upKind), .upTaken(upTaken),
    .upTarget(upTarget), .penCycles(penCycles)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  int          mCtr  [8192];
  int          mMark [8192];   // 0 none, 1 taken, 2 not-taken
  bit          mSeen [8192];
  logic [11:0] mHist [2];
  bit          mVld [32][4];
  logic [24:0] mTag [32][4];
  logic [31:0] mTgt [32][4];
  int          mAge [32][4];

  task automatic mReset();
    for (int i = 0; i < 8192; i++) begin mSeen[i] = 0; mCtr[i] = 1; mMark[i] = 0; end
    mHist[0] = '0; mHist[1] = '0;
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 4; w++) begin mVld[s][w] = 0; mAge[s][w] = w; end
  endtask

  function automatic int mIdx(logic [31:0] pc, logic tid);
    return int'({tid, mHist[tid] ^ pc[13:2]});
  endfunction

  function automatic bit mDir(int idx);
    if (!mSeen[idx]) return 1'b0;
    if (mMark[idx] == 1) return 1'b1;
    if (mMark[idx] == 2) return 1'b0;
    return mCtr[idx] >= 2;
  endfunction

  function automatic int mFind(logic [31:0] pc);
    for (int w = 0; w < 4; w++)
      if (mVld[pc[6:2]][w] && mTag[pc[6:2]][w] == pc[31:7]) return w;
    return -1;
  endfunction

  function automatic int mPen(logic v, logic [31:0] pc, logic tid, logic kind, logic tk);
    if (!v || kind) return 0;
    if (mDir(mIdx(pc, tid)) != tk) return 13;
    if (tk && mFind(pc) < 0) return 7;
    return 0;
  endfunction

  task automatic mUpdate(logic [31:0] pc, logic tid, logic kind, logic tk, logic [31:0] tgt);
    int idx, w, s;
    if (kind) return;
    idx = mIdx(pc, tid);
    if (!mSeen[idx]) begin
      mSeen[idx] = 1; mCtr[idx] = 1; mMark[idx] = tk ? 1 : 2;
    end else if (!((mMark[idx] == 1 && tk) || (mMark[idx] == 2 && !tk))) begin
      mMark[idx] = 0;
      if (tk && mCtr[idx] < 3) mCtr[idx]++;
      if (!tk && mCtr[idx] > 0) mCtr[idx]--;
    end
    if (tk) begin
      s = int'(pc[6:2]);
      w = mFind(pc);
      if (w < 0) begin
        for (int j = 3; j >= 0; j--) if (mAge[s][j] == 3) w = j;
        for (int j = 3; j >= 0; j--) if (!mVld[s][j]) w = j;
      end
      for (int j = 0; j < 4; j++)
        if (j != w && mAge[s][j] < mAge[s][w]) mAge[s][j]++;
      mAge[s][w] = 0;
      mVld[s][w] = 1; mTag[s][w] = pc[31:7]; mTgt[s][w] = tgt;
    end
    mHist[tid] = {mHist[tid][10:0], tk};
  endtask

  task automatic chk(string tag, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check lookup, clock the update, check penalty
  task automatic step(string tag, logic [31:0] lp, logic lt, logic lkd,
                      logic uv, logic [31:0] up, logic ut, logic ukd, logic utk,
                      logic [31:0] utg);
    int ei, ew, ep;
    bit eHit, eDir;
    @(negedge clk);
    lkPc = lp; lkTid = lt; lkKind = lkd;
    upValid = uv; upPc = up; upTid = ut; upKind = ukd; upTaken = utk; upTarget = utg;
    #1;
    ei = mIdx(lp, lt);
    ew = mFind(lp);
    eHit = !lkd && ew >= 0;
    eDir = mDir(ei);
    chk({tag, " R3 lkDir"}, lkDir == eDir, lkDir, eDir);
    chk({tag, " R7 tgtValid"}, tgtValid == eHit, tgtValid, eHit);
    chk({tag, " R9 predTaken"}, predTaken == (eHit && eDir), predTaken, eHit && eDir);
    if (eHit) chk({tag, " R7 target"}, predTarget == mTgt[lp[6:2]][ew], predTarget, mTgt[lp[6:2]][ew]);
    ep = mPen(uv, up, ut, ukd, utk);
    if (uv) mUpdate(up, ut, ukd, utk, utg);
    @(posedge clk);
    #1;
    chk({tag, " R10 penCycles"}, int'(penCycles) == ep, penCycles, ep);
    upValid = 1'b0;
  endtask

  task automatic look(string tag, logic [31:0] lp, logic lt);
    step(tag, lp, lt, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic upd(string tag, logic [31:0] p, logic t, logic k, logic tk, logic [31:0] g);
    step(tag, '0, 1'b0, 1'b0, 1'b1, p, t, k, tk, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [31:0] PC_A = 32'h0000_0a40;
  localparam logic [31:0] PC_B = 32'h0000_3b40;
  localparam logic [31:0] PC_C = PC_A + 32'h0000_4000;
  localparam logic [31:0] PC_D = PC_A + 32'h0000_8000;

  initial begin
    bit expSeq [9] = '{1, 0, 0, 0, 1, 1, 1, 1, 0};
    bit outSeq [9] = '{1, 0, 0, 1, 1, 1, 1, 0, 0};
    logic [31:0] p;
    void'($urandom(32'd1234));
    mReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 lkDir", lkDir == 1'b0, lkDir, 0);
    chk("R1 tgtValid", tgtValid == 1'b0, tgtValid, 0);
    chk("R1 predTaken", predTaken == 1'b0, predTaken, 0);
    chk("R1 penCycles", penCycles == 4'd0, penCycles, 0);

    // train PC_A on thread 0 with all-taken history
    for (int k = 0; k < 14; k++) begin
      upd("R4 train", PC_A, 1'b0, 1'b0, 1'b1, 32'h0000_1000 + k);
      if (k == 0) chk("R10 first taken of fresh entry", penCycles == 4'd13, penCycles, 13);
      if (k == 13) chk("R10 correct and hit", penCycles == 4'd0, penCycles, 0);
    end
    look("R4 look", PC_A, 1'b0);
    chk("R4 marked taken", lkDir == 1'b1, lkDir, 1);
    chk("R7 target kept", predTarget == 32'h0000_100d, predTarget, 32'h100d);
    chk("R9 hit taken", predTaken == 1'b1, predTaken, 1);

    upd("R10 tgt", PC_C, 1'b0, 1'b0, 1'b1, 32'h0000_2222);
    chk("R10 target miss", penCycles == 4'd7, penCycles, 7);
    look("R9 miss", PC_D, 1'b0);
    chk("R9 dir kept on miss", lkDir == 1'b1, lkDir, 1);
    chk("R9 forced not-taken", predTaken == 1'b0, predTaken, 0);

    look("R2 thread", PC_A, 1'b1);
    chk("R2 other thread fresh", lkDir == 1'b0, lkDir, 0);

    upd("R6 uncond", PC_A, 1'b0, 1'b1, 1'b0, 32'h0);
    chk("R6 uncond penalty", penCycles == 4'd0, penCycles, 0);
    look("R5 R6 history", PC_A, 1'b0);
    chk("R5 R6 history untouched", lkDir == 1'b1, lkDir, 1);
    upd("R6 uncond alloc", PC_B, 1'b0, 1'b1, 1'b1, 32'h0000_3333);
    look("R6 look", PC_B, 1'b0);
    chk("R6 no allocation", tgtValid == 1'b0, tgtValid, 0);
    step("R6 hint", PC_A, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
    chk("R6 uncond hint", tgtValid == 1'b0 && predTaken == 1'b0, tgtValid, 0);

    upd("R10 nt", PC_A, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R10 direction miss", penCycles == 4'd13, penCycles, 13);

    // R3 walk on one entry of thread 1, cancelling the history with PC bits
    for (int k = 0; k < 9; k++) begin
      p = {18'h0, 12'h5a5 ^ mHist[1], 2'b00};
      upd("R3 walk", p, 1'b1, 1'b0, outSeq[k], 32'h0000_4000 + k);
      p = {18'h0, 12'h5a5 ^ mHist[1], 2'b00};
      look("R3 walk look", p, 1'b1);
      chk(k < 2 ? "R4 mark step" : "R3 counter step", lkDir == expSeq[k], lkDir, expSeq[k]);
    end

    // R8 replacement in set 9
    for (int i = 0; i < 4; i++)
      upd("R8 fill", (32'(i + 1) << 7) | (32'd9 << 2), 1'b1, 1'b0, 1'b1, 32'h100 * (i + 1));
    upd("R8 refresh", (32'd1 << 7) | (32'd9 << 2), 1'b1, 1'b0, 1'b1, 32'h0000_0abc);
    upd("R8 evict", (32'd5 << 7) | (32'd9 << 2), 1'b1, 1'b0, 1'b1, 32'h0000_0500);
    look("R8 look", (32'd2 << 7) | (32'd9 << 2), 1'b1);
    chk("R8 oldest evicted", tgtValid == 1'b0, tgtValid, 0);
    look("R8 look", (32'd1 << 7) | (32'd9 << 2), 1'b1);
    chk("R8 refreshed kept", tgtValid == 1'b1, tgtValid, 1);
    chk("R7 refreshed target", predTarget == 32'h0000_0abc, predTarget, 32'habc);
    look("R8 look", (32'd5 << 7) | (32'd9 << 2), 1'b1);
    chk("R8 new way", tgtValid == 1'b1, tgtValid, 1);

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] lp, up;
      lp = (32'($urandom_range(0, 5)) << 7) | (32'($urandom_range(3, 4)) << 2);
      up = (32'($urandom_range(0, 5)) << 7) | (32'($urandom_range(3, 4)) << 2);
      step("RND", lp, 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 3) != 0), up, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)), $urandom);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule